// File: doc/BRIEF.md
# Multichannel serial ADC sequencer

This block runs eight serial converters side by side. A slow conversion clock paces a shared, active-low select line. Each period opens with a conversion phase in which the line is held high. The line then drops and stays low to allow readout. A faster system clock watches that line through a synchronizer. When it sees the line go low, the system clock toggles one shared serial clock for a fixed number of periods and shifts in every channel's data pin at the same moment.

When the last bit of a readout is in, the block updates all eight results together and marks them with one valid pulse of a single system cycle. Each result sits in a 14-bit container. A second output view gives each channel as a 16-bit word. That word is built from the low 12 bits of the result with four zero bits placed below them.

A conversion event can arrive while a readout is still running. Such an event is discarded, and a sticky overrun flag records that it happened.

Top module: `adc_seq_top`

## Requirements
- R1: While their resets are held, `adc_cs_n` and `adc_sclk` are 1, `smp_valid` and `ovr_flag` are 0, and all samples are 0.
- R2: After the conversion-domain reset is released, `adc_cs_n` stays 1 for the first full period of 250 conversion-clock cycles.
- R3: After that first period, `adc_cs_n` repeats a 250-cycle pattern. Counting `n` conversion-clock edges since reset release, `adc_cs_n` after edge `n` is 0 exactly when `n >= 250` and `n mod 250 >= 40`. It is therefore high for 40 cycles and low for 210 cycles of each period.
- R4: Each falling edge of `adc_cs_n` starts exactly one readout, provided no readout is in progress. The line is sampled by two system-clock flops followed by edge detection. `adc_sclk` first falls at the second system edge after the first edge that samples the line low.
- R5: A readout consists of 16 serial-clock periods. In each period `adc_sclk` is low for SCLK_HALF system cycles and then high for SCLK_HALF system cycles. Between readouts `adc_sclk` rests at 1.
- R6: Each channel's data pin `adc_sdo[c]` is sampled where `adc_sclk` rises, most significant bit first. The result keeps the last 14 of the 16 bits received, so the two leading bits are discarded. Channel `c` occupies `smp_raw[c*14 +: 14]`.
- R7: `smp_valid` is high for exactly one system cycle, SCLK_HALF cycles after the final rising serial edge. All channels update in that same cycle, and the samples hold their value between pulses.
- R8: `smp_fmt[c*16 +: 16]` equals bits 11..0 of channel `c`'s result followed by four 0 bits.
- R9: A conversion event detected while a readout is in progress, including its final cycle, starts no readout. It sets `ovr_flag`, which then stays 1 until the system reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for serial clocking and capture |
| rst | input | 1 | Synchronous active-high reset, system domain |
| cnv_clk | input | 1 | Conversion-cadence clock |
| cnv_rst | input | 1 | Synchronous active-high reset, conversion domain |
| adc_cs_n | output | 1 | Shared conversion / chip-select line, active low |
| adc_sclk | output | 1 | Shared serial clock, idle high |
| adc_sdo | input | NCH | Per-channel serial data pins |
| smp_raw | output | NCH*14 | 14-bit results, channel c at bits c*14 upward |
| smp_fmt | output | NCH*16 | 16-bit formatted results, channel c at bits c*16 upward |
| smp_valid | output | 1 | One-cycle pulse marking a new set of results |
| ovr_flag | output | 1 | Sticky flag for a dropped conversion event |

## Verification
The bench goes first after the silent first period and the exact 40/210 split of the select line. A design that is off by one in either count drifts against the per-edge model within a single period. The bench then checks the synchronizer delay and the serial-clock waveform cycle by cycle. An extra flop, or an edge detector that fires on the wrong polarity, shifts every serial edge and is reported at once.

The data patterns include words whose two leading bits are set while the trailing bits are clear, and alternating bits. A capture that keeps the first 14 bits, or that shifts in least significant bit first, therefore gives a visibly different result. The formatted view is compared against the expected value in every cycle.

Finally the system clock is slowed so that readouts outlast the conversion period. A design that restarted on a dropped event, or let the overrun flag clear, would produce extra valid pulses or a flag that falls back to 0.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Width of one stored result and of the formatted view
    localparam int SMP_BITS  = 14;
    localparam int FMT_BITS  = 16;
    localparam int KEEP_BITS = 12;
    localparam int PAD_BITS  = FMT_BITS - KEEP_BITS;

    // Readout sequencer phases
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_LOW  = 2'd1,
        RD_HIGH = 2'd2
    } rd_state_e;

    // Low part of the result, moved up with zero padding below
    function automatic logic [FMT_BITS-1:0] fmt_sample(input logic [SMP_BITS-1:0] r);
        return {r[KEEP_BITS-1:0], {PAD_BITS{1'b0}}};
    endfunction

endpackage

// File: rtl/adc_cnv_timer.sv
module adc_cnv_timer #(
    parameter int TERM = 249,
    parameter int HIGH = 40
) (
    input  logic cnv_clk,
    input  logic cnv_rst,
    output logic cs_n
);
    localparam int CW = $clog2(TERM + 1);

    logic [CW-1:0] cnt, cnt_nx;
    logic          armed, armed_nx, at_term;

    always_comb begin
        at_term  = (cnt == CW'(TERM));
        cnt_nx   = at_term ? '0 : cnt + CW'(1);
        armed_nx = armed | at_term;
    end

    always_ff @(posedge cnv_clk) begin
        if (cnv_rst) begin
            cnt   <= '0;
            armed <= 1'b0;
            cs_n  <= 1'b1;
        end else begin
            cnt   <= cnt_nx;
            armed <= armed_nx;
            // low (selected) only after the first full period, past the strobe
            cs_n  <= !(armed_nx && (cnt_nx >= CW'(HIGH)));
        end
    end

endmodule

// File: rtl/adc_event_sync.sv
module adc_event_sync (
    input  logic clk,
    input  logic rst,
    input  logic sel_async,
    output logic evt
);
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= sel_async;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign evt = sync_q & ~last_q;

endmodule

// File: rtl/adc_serial_capture.sv
module adc_serial_capture
    import adc_seq_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int HALF = 1,
    parameter int NCLK = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [NCH-1:0]            sdo,
    output logic                      sclk,
    output logic [NCH*SMP_BITS-1:0]   raw,
    output logic                      valid,
    output logic                      ovr
);
    localparam int HW = $clog2(HALF + 1);
    localparam int BW = $clog2(NCLK + 1);

    rd_state_e     st;
    logic [HW-1:0] hcnt;
    logic [BW-1:0] bcnt;
    logic          half_end, last_bit, cap_edge, done_edge;

    always_comb begin
        half_end  = (hcnt == HW'(HALF - 1));
        last_bit  = (bcnt == BW'(NCLK - 1));
        cap_edge  = (st == RD_LOW) && half_end;
        done_edge = (st == RD_HIGH) && half_end && last_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= RD_IDLE;
            sclk  <= 1'b1;
            hcnt  <= '0;
            bcnt  <= '0;
            valid <= 1'b0;
            ovr   <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (start && (st != RD_IDLE))
                ovr <= 1'b1;
            case (st)
                RD_IDLE: begin
                    if (start) begin
                        st   <= RD_LOW;
                        sclk <= 1'b0;
                        hcnt <= '0;
                        bcnt <= '0;
                    end
                end
                RD_LOW: begin
                    if (half_end) begin
                        st   <= RD_HIGH;
                        sclk <= 1'b1;
                        hcnt <= '0;
                    end else begin
                        hcnt <= hcnt + HW'(1);
                    end
                end
                RD_HIGH: begin
                    if (half_end) begin
                        hcnt <= '0;
                        if (last_bit) begin
                            st    <= RD_IDLE;
                            valid <= 1'b1;
                        end else begin
                            bcnt <= bcnt + BW'(1);
                            st   <= RD_LOW;
                            sclk <= 1'b0;
                        end
                    end else begin
                        hcnt <= hcnt + HW'(1);
                    end
                end
                default: st <= RD_IDLE;
            endcase
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        logic [SMP_BITS-1:0] shreg;
        always_ff @(posedge clk) begin
            if (rst) begin
                shreg                       <= '0;
                raw[c*SMP_BITS +: SMP_BITS] <= '0;
            end else begin
                if (cap_edge)
                    shreg <= {shreg[SMP_BITS-2:0], sdo[c]};
                if (done_edge)
                    raw[c*SMP_BITS +: SMP_BITS] <= shreg;
            end
        end
    end

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int CNV_TERM   = 249,
    parameter int CNV_HIGH   = 40,
    parameter int SCLK_HALF  = 1,
    parameter int SCLK_COUNT = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cnv_clk,
    input  logic                    cnv_rst,
    output logic                    adc_cs_n,
    output logic                    adc_sclk,
    input  logic [NCH-1:0]          adc_sdo,
    output logic [NCH*SMP_BITS-1:0] smp_raw,
    output logic [NCH*FMT_BITS-1:0] smp_fmt,
    output logic                    smp_valid,
    output logic                    ovr_flag
);
    logic evt;

    adc_cnv_timer #(
        .TERM (CNV_TERM),
        .HIGH (CNV_HIGH)
    ) u_timer (
        .cnv_clk (cnv_clk),
        .cnv_rst (cnv_rst),
        .cs_n    (adc_cs_n)
    );

    adc_event_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .sel_async (~adc_cs_n),
        .evt       (evt)
    );

    adc_serial_capture #(
        .NCH  (NCH),
        .HALF (SCLK_HALF),
        .NCLK (SCLK_COUNT)
    ) u_cap (
        .clk   (clk),
        .rst   (rst),
        .start (evt),
        .sdo   (adc_sdo),
        .sclk  (adc_sclk),
        .raw   (smp_raw),
        .valid (smp_valid),
        .ovr   (ovr_flag)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_fmt
        assign smp_fmt[c*FMT_BITS +: FMT_BITS] = fmt_sample(smp_raw[c*SMP_BITS +: SMP_BITS]);
    end

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int RAW_W = 112
) (
    input logic             clk,
    input logic             rst,
    input logic             cnv_clk,
    input logic             cnv_rst,
    input logic             adc_cs_n,
    input logic             adc_sclk,
    input logic             smp_valid,
    input logic             ovr_flag,
    input logic [RAW_W-1:0] smp_raw
);
    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid);

    // R7
    sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |-> $stable(smp_raw));

    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovr_flag |=> ovr_flag);

    // R5
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> adc_sclk);

    // R3
    strobe_width_chk: assert property (@(posedge cnv_clk) disable iff (cnv_rst)
        $rose(adc_cs_n) |=> adc_cs_n);

endmodule

bind adc_seq_top adc_seq_chk #(.RAW_W(NCH*adc_seq_pkg::SMP_BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnv_clk   (cnv_clk),
    .cnv_rst   (cnv_rst),
    .adc_cs_n  (adc_cs_n),
    .adc_sclk  (adc_sclk),
    .smp_valid (smp_valid),
    .ovr_flag  (ovr_flag),
    .smp_raw   (smp_raw)
);

// File: tb/adc_seq_top_bench.sv
`timescale 1ns/10ps
module adc_seq_top_bench;
    localparam int  SYS_HALF_NS  = 20;
    localparam int  SLOW_HALF_NS = 200;
    localparam real CNV_HALF_NS  = 20.35;
    localparam int  NCH    = 8;
    localparam int  SB     = 14;
    localparam int  FB     = 16;
    localparam int  PERIOD = 250;
    localparam int  HIGHC  = 40;
    localparam int  HALF   = 1;
    localparam int  NCLK   = 16;
    localparam int  WDOG   = 20000;

    logic clk = 1'b0, cnv_clk = 1'b0, rst = 1'b1, cnv_rst = 1'b1;
    logic [NCH-1:0]    sdo = '0;
    logic              adc_cs_n, adc_sclk, smp_valid, ovr_flag;
    logic [NCH*SB-1:0] smp_raw;
    logic [NCH*FB-1:0] smp_fmt;

    int sys_half = SYS_HALF_NS;
    always #(sys_half) clk = ~clk;
    initial begin
        #0.1;
        forever #(CNV_HALF_NS) cnv_clk = ~cnv_clk;
    end

    adc_seq_top u_adc_seq_top (
        .clk(clk), .rst(rst), .cnv_clk(cnv_clk), .cnv_rst(cnv_rst),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdo(sdo),
        .smp_raw(smp_raw), .smp_fmt(smp_fmt),
        .smp_valid(smp_valid), .ovr_flag(ovr_flag)
    );

    int n_chk = 0, n_err = 0;
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] gen_word(input int n, input int ch);
        case (n)
            0: return 16'hFFFF;
            1: return 16'h0000;
            2: return 16'hC001 ^ 16'(ch << 4);
            3: return 16'h5555 ^ 16'(ch);
            default: return 16'(((n * 16'h9E37) ^ (ch * 16'h3B1D)) + 16'h1234);
        endcase
    endfunction

    // conversion-domain model
    int cn = 0, nfall = 0;
    bit prev_cs = 1'b1;
    always @(posedge cnv_clk) begin
        bit e_cs;
        if (cnv_rst) cn = 0; else cn++;
        e_cs = !((cn >= PERIOD) && ((cn % PERIOD) >= HIGHC));
        if (prev_cs && !e_cs) nfall++;
        prev_cs = e_cs;
        #1;
        if (cnv_rst)           chk("R1", "cs_n in reset", 32'(adc_cs_n), 32'(e_cs));
        else if (cn < PERIOD)  chk("R2", "cs_n first period", 32'(adc_cs_n), 32'(e_cs));
        else                   chk("R3", "cs_n cadence", 32'(adc_cs_n), 32'(e_cs));
    end

    // converter model: new bit after each falling serial edge, MSB first
    logic [NCH*16-1:0] wq[$];
    logic [15:0] words[NCH];
    int fc = 0, conv_n = 0;
    always @(negedge adc_sclk) begin
        #1;
        if (fc == 0) begin
            logic [NCH*16-1:0] pk;
            for (int ch = 0; ch < NCH; ch++) begin
                words[ch] = gen_word(conv_n, ch);
                pk[ch*16 +: 16] = words[ch];
            end
            wq.push_back(pk);
            conv_n++;
        end
        for (int ch = 0; ch < NCH; ch++) sdo[ch] = words[ch][15-fc];
        fc = (fc + 1) % NCLK;
    end

    // system-domain model
    bit dl1, dl2, dl3, running, e_sclk = 1'b1, e_valid, e_ovr;
    int t = 0, nstart = 0, nvalid = 0, dut_valid = 0;
    logic [SB-1:0] e_raw[NCH];
    initial for (int ch = 0; ch < NCH; ch++) e_raw[ch] = '0;

    always @(posedge clk) begin
        bit ev, was, lowseen;
        lowseen = !adc_cs_n;
        if (rst) begin
            dl1 = 0; dl2 = 0; dl3 = 0; running = 0; t = 0;
            e_sclk = 1; e_valid = 0; e_ovr = 0;
            for (int ch = 0; ch < NCH; ch++) e_raw[ch] = '0;
        end else begin
            ev = dl2 && !dl3;
            dl3 = dl2; dl2 = dl1; dl1 = lowseen;
            e_valid = 0;
            was = running;
            if (ev && was) e_ovr = 1;
            if (was) begin
                t++;
                if (t == 2 * HALF * NCLK) begin
                    running = 0; e_sclk = 1; e_valid = 1; nvalid++;
                    if (wq.size() == 0) begin
                        chk("R6", "missing converter word", 32'd0, 32'd1);
                    end else begin
                        logic [NCH*16-1:0] pk;
                        pk = wq.pop_front();
                        for (int ch = 0; ch < NCH; ch++) e_raw[ch] = pk[ch*16 +: SB];
                    end
                end else begin
                    e_sclk = ((t / HALF) % 2) == 1;
                end
            end else if (ev) begin
                running = 1; t = 0; e_sclk = 0; nstart++;
            end
        end
        #1;
        if (smp_valid === 1'b1) dut_valid++;
        chk(rst ? "R1" : "R5", "sclk", 32'(adc_sclk), 32'(e_sclk));
        chk(rst ? "R1" : "R7", "valid", 32'(smp_valid), 32'(e_valid));
        chk(rst ? "R1" : "R9", "overrun", 32'(ovr_flag), 32'(e_ovr));
        for (int ch = 0; ch < NCH; ch++) begin
            chk(rst ? "R1" : "R6", $sformatf("raw ch%0d", ch),
                32'(smp_raw[ch*SB +: SB]), 32'(e_raw[ch]));
            chk("R8", $sformatf("fmt ch%0d", ch),
                32'(smp_fmt[ch*FB +: FB]), 32'({e_raw[ch][11:0], 4'h0}));
        end
    end

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        cnv_rst = 1'b0;
        while (nvalid < 8) @(negedge clk);
        // R4: one readout per select falling edge, none lost
        chk("R4", "starts per falling edge", 32'(nstart), 32'(nfall));
        chk("R4", "dut valid pulses", 32'(dut_valid), 32'(nvalid));
        chk("R9", "no overrun at normal rate", 32'(ovr_flag), 32'd0);
        sys_half = SLOW_HALF_NS;
        while (nvalid < 11) @(negedge clk);
        chk("R9", "overrun after slow readouts", 32'(ovr_flag), 32'd1);
        chk("R9", "dropped events start nothing", 32'(dut_valid), 32'(nvalid));
        chk("R4", "fewer starts than edges", 32'(nstart < nfall), 32'd1);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule